// File: doc/BRIEF.md
# I2C Device-Side Bit Engine

This block is the bit-level part of an I2C target. It watches open-drain SCL and SDA through a clock-enable sampler and a three-sample majority filter. It tells a controlling layer about each bus event: a start, a repeated start, a stop, each data bit clocked on a rising SCL edge, and an abandoned transfer. Byte assembly, addressing and register access belong to the controlling layer, which answers every bit with a one-entry response: either release SDA, or drive SDA with a given value.

When SCL falls during a transfer, the engine releases SDA and takes the pending response. If no response has arrived yet, it holds SCL low until one does. It then waits a programmed setup interval before it applies the new SDA level, and only after that does it let go of SCL. A stall timer drops the transfer when SCL stays at one level for too long.

Top module: `i2cb_slave_engine`

## Requirements
- R1: After reset both line outputs are high (released), `rsp_ready` is low and no event is reported.
- R2: SDA falling while SCL is high reports kind 0 (start) when idle and kind 1 (restart) during a transfer. Either one discards any pending response and releases SDA.
- R3: SDA rising while SCL is high during a transfer reports kind 2 (stop). The engine then returns to idle with both lines released and `rsp_ready` low.
- R4: Every rising SCL edge after the drive phase of a transfer reports kind 3 (bit). `evt_bit` carries the SDA level seen on the bus at that edge.
- R5: A response with `rsp_drive`=1 and `rsp_value`=0 pulls SDA low for the bit that follows. Any other response leaves SDA released, so the bus bit is master AND (value OR NOT drive).
- R6: After SCL falls during a transfer, `scl_o` stays low until a response has been accepted and the setup interval has elapsed.
- R7: When the engine is already stretching and a response is accepted on clock edge E, `sda_o` takes the new level and `scl_o` is released after edge E + `cfg_setup` + 2, and not earlier.
- R8: During a transfer, if filtered SCL holds one level for `cfg_timeout` clock cycles, the engine reports kind 4 (drop), goes idle and releases both lines.
- R9: Line samples are taken once every `cfg_sample_div`+1 clock cycles. A pulse shorter than one sample period on either line produces no event.
- R10: `rsp_ready` is high only during a transfer while the single response slot is empty. A response is accepted on a clock edge where both `rsp_valid` and `rsp_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sample_div | input | DIV_W | Sample period minus one, in clock cycles |
| cfg_timeout | input | TMO_W | SCL stall limit in clock cycles |
| cfg_setup | input | TSU_W | Data setup interval before SDA is applied |
| scl_i | input | 1 | SCL level read from the bus |
| sda_i | input | 1 | SDA level read from the bus |
| scl_o | output | 1 | SCL write, 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA write, 0 pulls low, 1 releases |
| rsp_valid | input | 1 | Response offered by the controller |
| rsp_drive | input | 1 | Response drives SDA when 1 |
| rsp_value | input | 1 | Level to drive when `rsp_drive` is 1 |
| rsp_ready | output | 1 | Response slot empty during a transfer |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_kind | output | 3 | 0 start, 1 restart, 2 stop, 3 bit, 4 drop |
| evt_bit | output | 1 | Sampled SDA level for a bit event |

## Verification
The hardest case to reach is the exact cycle relation between accepting a late response and releasing the stretched SCL. It only appears after the bench master has raised its own SCL and found the bus held low. The stimulus gets there by withholding the response for a chosen number of cycles while the master waits. It then checks every cycle from acceptance until SDA changes. The bench also randomises these withholding delays across frames, and it lets one transfer starve completely so the stall timer fires while the engine itself is stretching.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [2:0] {
        EV_START   = 3'd0,
        EV_RESTART = 3'd1,
        EV_STOP    = 3'd2,
        EV_BIT     = 3'd3,
        EV_DROP    = 3'd4
    } evt_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_HIGH  = 3'd1,
        PH_LOAD  = 3'd2,
        PH_SETUP = 3'd3,
        PH_DRIVE = 3'd4
    } phase_e;

    typedef struct packed {
        logic drive;
        logic value;
    } bit_rsp_t;

    localparam int NUM_LINES = 2;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;

    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

    function automatic logic pulls_low(input bit_rsp_t r);
        return r.drive & ~r.value;
    endfunction

endpackage

// File: rtl/i2cb_sample_tick.sv
module i2cb_sample_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= tick ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/i2cb_line_filter.sv
module i2cb_line_filter (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    output logic clean
);
    import i2cb_pkg::*;

    logic [1:0] sync;
    logic [1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= 2'b11;
            hist  <= 2'b11;
            clean <= 1'b1;
        end else begin
            sync <= {sync[0], raw};
            if (tick) begin
                hist  <= {hist[0], sync[1]};
                clean <= maj3({hist, sync[1]});
            end
        end
    end

    AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(clean)); // R9
endmodule

// File: rtl/i2cb_stall_timer.sv
module i2cb_stall_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             line,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;
    logic             line_q;

    assign expired = run && (line == line_q) && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            line_q <= 1'b1;
        end else begin
            line_q <= line;
            if (!run || line != line_q) cnt <= '0;
            else if (cnt < limit)       cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cb_slave_engine.sv
module i2cb_slave_engine #(
    parameter int DIV_W = 8,
    parameter int TMO_W = 16,
    parameter int TSU_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_sample_div,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic [TSU_W-1:0] cfg_setup,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_o,
    output logic             sda_o,
    input  logic             rsp_valid,
    input  logic             rsp_drive,
    input  logic             rsp_value,
    output logic             rsp_ready,
    output logic             evt_valid,
    output logic [2:0]       evt_kind,
    output logic             evt_bit
);
    import i2cb_pkg::*;

    logic                 tick;
    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean_lines;
    logic                 scl_f, sda_f, scl_q, sda_q;
    logic                 tmo_hit;

    phase_e               phase;
    bit_rsp_t             slot, cur;
    logic                 slot_vld;
    logic [TSU_W-1:0]     su_cnt;
    evt_kind_e            kind_q;

    assign raw_lines[LINE_SCL] = scl_i;
    assign raw_lines[LINE_SDA] = sda_i;

    i2cb_sample_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .div(cfg_sample_div), .tick(tick)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
        i2cb_line_filter u_filt (
            .clk(clk), .rst(rst), .tick(tick),
            .raw(raw_lines[g]), .clean(clean_lines[g])
        );
    end

    assign scl_f = clean_lines[LINE_SCL];
    assign sda_f = clean_lines[LINE_SDA];

    i2cb_stall_timer #(.TMO_W(TMO_W)) u_stall (
        .clk(clk), .rst(rst), .run(phase != PH_IDLE),
        .line(scl_f), .limit(cfg_timeout), .expired(tmo_hit)
    );

    logic start_det, stop_det, scl_rise, scl_fall, accept;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;

    assign rsp_ready = (phase != PH_IDLE) && !slot_vld;
    assign accept    = rsp_valid && rsp_ready;
    assign scl_o     = !(phase == PH_LOAD || phase == PH_SETUP);
    assign sda_o     = !((phase == PH_DRIVE || phase == PH_HIGH) && pulls_low(cur));
    assign evt_kind  = kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            slot      <= '0;
            cur       <= '0;
            slot_vld  <= 1'b0;
            su_cnt    <= '0;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            evt_valid <= 1'b0;
            kind_q    <= EV_START;
            evt_bit   <= 1'b0;
        end else begin
            scl_q     <= scl_f;
            sda_q     <= sda_f;
            evt_valid <= 1'b0;
            if (accept) begin
                slot     <= '{drive: rsp_drive, value: rsp_value};
                slot_vld <= 1'b1;
            end
            if (tmo_hit) begin
                phase     <= PH_IDLE;
                cur       <= '0;
                slot_vld  <= 1'b0;
                evt_valid <= 1'b1;
                kind_q    <= EV_DROP;
            end else if (start_det) begin
                phase     <= PH_HIGH;
                cur       <= '0;
                slot_vld  <= 1'b0;
                evt_valid <= 1'b1;
                kind_q    <= (phase == PH_IDLE) ? EV_START : EV_RESTART;
            end else if (stop_det && phase != PH_IDLE) begin
                phase     <= PH_IDLE;
                cur       <= '0;
                slot_vld  <= 1'b0;
                evt_valid <= 1'b1;
                kind_q    <= EV_STOP;
            end else begin
                unique case (phase)
                    PH_HIGH: if (scl_fall) begin
                        phase <= PH_LOAD;
                        cur   <= '0;
                    end
                    PH_LOAD: if (slot_vld) begin
                        phase    <= PH_SETUP;
                        cur      <= slot;
                        slot_vld <= 1'b0;
                        su_cnt   <= '0;
                    end
                    PH_SETUP: begin
                        if (su_cnt >= cfg_setup) phase  <= PH_DRIVE;
                        else                     su_cnt <= su_cnt + 1'b1;
                    end
                    PH_DRIVE: if (scl_rise) begin
                        phase     <= PH_HIGH;
                        evt_valid <= 1'b1;
                        kind_q    <= EV_BIT;
                        evt_bit   <= sda_f;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_END_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && (kind_q == EV_STOP || kind_q == EV_DROP)) |-> (scl_o && sda_o && !rsp_ready)); // R3
    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (rst)
        accept |=> !rsp_ready); // R10
    AST_SDA_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_o) |-> $past(phase) == PH_SETUP); // R7
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && !slot_vld && !tmo_hit) |=> !scl_o); // R6
    AST_BIT_FROM_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && kind_q == EV_BIT) |-> $past(phase) == PH_DRIVE); // R4
    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (rst)
        tmo_hit |=> (phase == PH_IDLE)); // R8
endmodule

// File: tb/i2cb_slave_engine_test.sv
module i2cb_slave_engine_test;
    import i2cb_pkg::*;

    localparam int Q   = 40;
    localparam int DIV = 3;
    localparam int TMO = 1000;
    localparam int SU  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic rsp_valid = 1'b0, rsp_drive = 1'b0, rsp_value = 1'b0;
    logic scl_o, sda_o, rsp_ready, evt_valid, evt_bit;
    logic [2:0] evt_kind;
    logic scl_bus, sda_bus;

    int checks = 0, errors = 0;
    int ev_n = 0;
    logic [2:0] ev_k = 3'd7;
    logic ev_b = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign scl_bus = scl_m & scl_o;
    assign sda_bus = sda_m & sda_o;

    i2cb_slave_engine uut (
        .clk(clk), .rst(rst),
        .cfg_sample_div(8'(DIV)), .cfg_timeout(16'(TMO)), .cfg_setup(8'(SU)),
        .scl_i(scl_bus), .sda_i(sda_bus), .scl_o(scl_o), .sda_o(sda_o),
        .rsp_valid(rsp_valid), .rsp_drive(rsp_drive), .rsp_value(rsp_value),
        .rsp_ready(rsp_ready), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_bit(evt_bit)
    );

    always @(negedge clk) if (evt_valid) begin
        ev_n++;
        ev_k = evt_kind;
        ev_b = evt_bit;
    end

    function automatic logic exp_bus(logic mb, logic drv, logic val);
        return mb & (~drv | val);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic give_rsp(input logic drv, input logic val);
        while (!rsp_ready) @(negedge clk);
        rsp_drive = drv; rsp_value = val; rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic m_start(input logic [2:0] kind);
        sda_m = 1'b0; wq(Q);
        check(ev_k == kind, "R2 start kind", ev_k, kind);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_bit(input logic mb, input logic drv, input logic val, input int dly);
        logic e;
        bit held;
        int n0;
        e = exp_bus(mb, drv, val);
        n0 = ev_n;
        if (dly == 0) begin
            give_rsp(drv, val);
            sda_m = mb; wq(Q); scl_m = 1'b1;
        end else begin
            sda_m = mb; wq(Q); scl_m = 1'b1;
            held = 1'b1;
            for (int j = 0; j < dly; j++) begin
                @(negedge clk);
                if (scl_bus) held = 1'b0;
            end
            check(held, "R6 stretch before response", held, 1);
            give_rsp(drv, val);
        end
        while (!scl_bus) @(negedge clk);
        wq(Q);
        check(sda_bus == e, "R5 bus level", sda_bus, e);
        check(ev_k == EV_BIT && ev_b == e && ev_n == n0 + 1, "R4 bit event", {ev_k, ev_b}, {EV_BIT, e});
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        give_rsp(1'b0, 1'b0);
        sda_m = 1'b0; wq(Q); scl_m = 1'b1;
        while (!scl_bus) @(negedge clk);
        wq(Q);
        sda_m = 1'b1; wq(Q);
        check(ev_k == EV_STOP, "R3 stop kind", ev_k, EV_STOP);
        check(scl_o && sda_o && !rsp_ready, "R3 released", {scl_o, sda_o, rsp_ready}, 3'b110);
    endtask

    task automatic m_restart();
        give_rsp(1'b0, 1'b0);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1;
        while (!scl_bus) @(negedge clk);
        wq(Q);
        m_start(EV_RESTART);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        int n0;
        bit ok;
        void'($urandom(32'd1357));
        wq(3);
        check(scl_o && sda_o && !rsp_ready && !evt_valid, "R1 reset state",
              {scl_o, sda_o, rsp_ready, evt_valid}, 4'b1100);
        rst = 1'b0;
        wq(Q);
        check(ev_n == 0 && rsp_ready == 0, "R1 idle after reset", ev_n, 0);

        // R9: short glitches while idle produce no event
        n0 = ev_n;
        sda_m = 1'b0; wq(2); sda_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(2); scl_m = 1'b1; wq(Q);
        check(ev_n == n0, "R9 glitch rejected", ev_n, n0);

        // Directed frame: start, bits, stop
        m_start(EV_START);
        check(rsp_ready == 1'b1, "R10 ready in transfer", rsp_ready, 1);
        m_bit(1, 1, 0, 0);
        m_bit(1, 0, 0, 0);
        m_bit(0, 1, 1, 0);
        m_bit(1, 1, 1, 30);

        // R7: exact setup timing after a late response
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(20);
        while (!rsp_ready) @(negedge clk);
        rsp_drive = 1'b1; rsp_value = 1'b0; rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        check(!rsp_ready, "R10 slot filled", rsp_ready, 0);
        ok = 1'b1;
        for (int j = 1; j <= SU + 1; j++) begin
            @(negedge clk);
            if (!sda_o || scl_o) ok = 1'b0;
        end
        check(ok, "R7 held through setup", ok, 1);
        @(negedge clk);
        check(!sda_o && scl_o, "R7 applied after setup", {sda_o, scl_o}, 2'b01);
        while (!scl_bus) @(negedge clk);
        wq(Q);
        check(ev_k == EV_BIT && ev_b == 1'b0, "R4 bit after setup", ev_b, 0);
        scl_m = 1'b0; wq(Q);
        m_restart();
        m_bit(0, 0, 0, 0);
        m_stop();

        // Random frames
        for (int f = 0; f < 6; f++) begin
            int nb;
            m_start(EV_START);
            nb = 1 + int'($urandom_range(5));
            for (int b = 0; b < nb; b++) begin
                int d;
                d = ($urandom_range(1) == 1) ? int'($urandom_range(40, 5)) : 0;
                m_bit(1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)), d);
                if (b == nb / 2 && $urandom_range(2) == 0) m_restart();
            end
            m_stop();
        end

        // R8: starve the engine until the stall timer fires
        m_start(EV_START);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1;
        wq(TMO + 100);
        check(ev_k == EV_DROP, "R8 drop kind", ev_k, EV_DROP);
        check(scl_bus && sda_o && !rsp_ready, "R8 released after drop",
              {scl_bus, sda_o, rsp_ready}, 3'b110);
        n0 = ev_n;
        wq(Q);
        check(ev_n == n0, "R8 quiet after drop", ev_n, n0);

        // Engine recovers for a new frame
        m_start(EV_START);
        m_bit(0, 1, 0, 0);
        m_stop();

        done = 1'b1;
        summary();
    end
endmodule